// File: doc/BRIEF.md
# Uplink pause-interval Manchester decoder

This block turns the card-to-reader direction of a proximity link back into data. Its input is a single digital flag that is high-low toggling while the card load-modulates its subcarrier and steady while it does not. The block never samples half-bits one by one. Instead it finds the quiet gaps in the modulation and measures the time from one gap to the next. It sorts that time into two, three or four half-bit periods. From the class of each gap, and from whether the running half-bit total is odd or even, it rebuilds the data bits.

The decoded bits are packed into bytes, least-significant bit first. Parity bits stay in the stream. Each byte appears as a one-cycle strobe. At the end of a frame, any partial byte is emitted right-aligned, together with a frame-done strobe, the total bit count and a flag saying whether the frame is long enough to count. All timing limits are parameters given in interval-counter ticks. A prescaler sets how many clocks make one tick. A re-arm input discards a frame that is in progress.

Top module: `uplink_pause_decoder`

## Requirements
- R1: While reset is low, and in the first sampled cycle after it, `byte_valid` and `frame_done` are 0.
- R2: After the first rising edge of `mod_in`, a pause is declared once `mod_in` has held still for PAUSE_TICKS ticks (default 24, which is three quarters of a 32-tick half-bit). Any change of `mod_in` restarts that wait.
- R3: An interval between pauses of at most LIM_ONE ticks (default 48) adds no bits and leaves the half-bit phase unchanged. This includes the zero reading at a frame's first pause.
- R4: An interval of LIM_ONE+1 to LIM_TWO ticks (default 80) is two half-bits. In odd phase it yields a 1. In even phase it yields a 0.
- R5: An interval of LIM_TWO+1 to LIM_THREE ticks (default 112) is three half-bits. In odd phase it yields 1 then 0. In even phase it yields 0. The phase flips.
- R6: A longer interval is four half-bits. In odd phase it yields 1 then 0. In even phase it yields nothing.
- R7: The half-bit total starts odd at frame start. The leading 1 of the first classified interval is dropped, because it stands for the start-of-frame modulation.
- R8: A frame ends once EOF_TICKS ticks (default 160) pass without a pause. If the phase is odd at that point, one final 1 bit is added.
- R9: Bits are packed with the first bit in byte bit 0. Each completed byte is shown on `byte_data` with a one-cycle `byte_valid`.
- R10: If the frame bit count is not a multiple of 8, the last bits are emitted right-aligned (the first of them in bit 0, upper bits 0), with `byte_valid` in the same cycle as `frame_done`.
- R11: `frame_done` pulses once per frame. At that pulse, `frame_bits` holds the number of decoded bits, and `frame_ok` is 1 exactly when that number is at least MIN_BITS (default 4).
- R12: While `rearm` is high, the frame state clears, no output strobes appear and `mod_in` is ignored. Decoding resumes normally after release. The interval counter saturates rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rearm | input | 1 | Discard the current frame and wait for a new one |
| mod_in | input | 1 | Modulation-present flag; toggles while the card modulates |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Decoded byte, first bit in bit 0 |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| frame_bits | output | BCNT_W | Decoded bit count, valid with `frame_done` |
| frame_ok | output | 1 | Frame met the minimum length, valid with `frame_done` |

## Verification
The bench builds the block with TICK_DIV = 1, so one tick equals one clock. A half-bit is then exactly 32 clocks, and the subcarrier toggling can be drawn clock by clock. The bench also sets BCNT_W = 8. With these values, frames from one bit up to 27 bits finish in a few thousand cycles each. That puts the byte-boundary crossings, the right-aligned partial byte and the minimum-length edge within easy reach. Hand-built half-bit patterns reach the even-phase four-half-bit case and a short glitch interval, which valid encoding never produces.

// File: rtl/upd_pkg.sv
package upd_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      CLS_NONE  = 2'd0,
      CLS_TWO   = 2'd1,
      CLS_THREE = 2'd2,
      CLS_FOUR  = 2'd3
   } gap_cls_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_LIVE = 1'b1
   } dec_state_t;
endpackage

// File: rtl/upd_tick_gen.sv
module upd_tick_gen #(
   parameter int TICK_DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   initial begin
      assert (TICK_DIV >= 1) else $error("TICK_DIV must be at least 1");
   end

   generate
      if (TICK_DIV == 1) begin : g_direct
         logic run_q;
         always_ff @(posedge clk) run_q <= rst_n;
         assign tick_o = run_q;
      end else begin : g_div
         localparam int DW = $clog2(TICK_DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n) div_q <= '0;
            else if (div_q == DW'(TICK_DIV - 1)) div_q <= '0;
            else div_q <= div_q + DW'(1);
         end
         assign tick_o = (div_q == DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/upd_pause_det.sv
module upd_pause_det #(
   parameter int PAUSE_TICKS = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic tick_i,
   input  logic edge_i,
   output logic pause_o
);
   localparam int PC_W = $clog2(PAUSE_TICKS + 1);

   logic [PC_W-1:0] quiet_q;
   logic            fired_q;

   initial begin
      assert (PAUSE_TICKS >= 2) else $error("PAUSE_TICKS must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !act_i) begin
         quiet_q <= '0;
         fired_q <= 1'b0;
         pause_o <= 1'b0;
      end else begin
         pause_o <= 1'b0;
         if (edge_i) begin
            quiet_q <= '0;
            fired_q <= 1'b0;
         end else if (tick_i && !fired_q) begin
            if (quiet_q == PC_W'(PAUSE_TICKS - 1)) begin
               quiet_q <= '0;
               fired_q <= 1'b1;
               pause_o <= 1'b1;
            end else begin
               quiet_q <= quiet_q + PC_W'(1);
            end
         end
      end
   end

   // R2: a fresh edge is never directly followed by a pause
   p_edge_no_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_i |=> !pause_o);
   // R2: one pause per quiet stretch, never two back to back
   p_pause_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pause_o |=> !pause_o);
endmodule

// File: rtl/upd_gap_timer.sv
module upd_gap_timer
   import upd_pkg::*;
#(
   parameter int LIM_ONE   = 48,
   parameter int LIM_TWO   = 80,
   parameter int LIM_THREE = 112,
   parameter int EOF_TICKS = 160
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     act_i,
   input  logic     tick_i,
   input  logic     pause_i,
   output logic     ev_o,
   output gap_cls_t cls_o,
   output logic     eof_o
);
   localparam int              IC_W   = $clog2(EOF_TICKS + 1);
   localparam logic [IC_W-1:0] IC_MAX = '1;

   logic [IC_W-1:0] gap_q;
   logic            run_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !act_i) begin
         gap_q <= '0;
         run_q <= 1'b0;
      end else if (pause_i) begin
         gap_q <= '0;
         run_q <= 1'b1;
      end else if (run_q && tick_i && gap_q != IC_MAX) begin
         gap_q <= gap_q + IC_W'(1);
      end
   end

   always_comb begin
      if (int'(gap_q) <= LIM_ONE)        cls_o = CLS_NONE;
      else if (int'(gap_q) <= LIM_TWO)   cls_o = CLS_TWO;
      else if (int'(gap_q) <= LIM_THREE) cls_o = CLS_THREE;
      else                               cls_o = CLS_FOUR;
   end

   assign ev_o  = pause_i;
   assign eof_o = run_q && !pause_i && (int'(gap_q) >= EOF_TICKS);

   // R3: the first pause of a frame always reads an empty interval
   p_first_gap_none_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && pause_i && !run_q) |-> cls_o == CLS_NONE);
   // R12: the interval counter holds at its ceiling instead of wrapping
   p_gap_saturate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i && !pause_i && gap_q == IC_MAX) |=> (gap_q == IC_MAX || gap_q == '0));
endmodule

// File: rtl/upd_bit_packer.sv
module upd_bit_packer
   import upd_pkg::*;
#(
   parameter int BCNT_W   = 12,
   parameter int MIN_BITS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [1:0]        nb_i,
   input  logic              b0_i,
   input  logic              b1_i,
   input  logic              flush_i,
   output logic [BCNT_W-1:0] cnt_o,
   output logic              byte_valid_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              done_o,
   output logic [BCNT_W-1:0] bits_o,
   output logic              ok_o
);
   localparam int POS_W = $clog2(BYTE_W);

   logic [BYTE_W-1:0] sreg_q, s_nx, bd_nx;
   logic [BCNT_W-1:0] cnt_q, c_nx;
   logic              bv_nx;
   logic [POS_W-1:0]  rem;

   initial begin
      assert (BCNT_W > POS_W) else $error("BCNT_W too small");
      assert (MIN_BITS >= 1) else $error("MIN_BITS must be positive");
   end

   always_comb begin
      s_nx  = sreg_q;
      c_nx  = cnt_q;
      bv_nx = 1'b0;
      bd_nx = '0;
      for (int i = 0; i < 2; i++) begin
         if (i < int'(nb_i)) begin
            s_nx = {(i == 0) ? b0_i : b1_i, s_nx[BYTE_W-1:1]};
            c_nx = c_nx + BCNT_W'(1);
            if (c_nx[POS_W-1:0] == '0) begin
               bv_nx = 1'b1;
               bd_nx = s_nx;
            end
         end
      end
      rem = c_nx[POS_W-1:0];
      if (flush_i && rem != '0) begin
         bv_nx = 1'b1;
         bd_nx = s_nx >> (POS_W + 1)'(BYTE_W - int'(rem));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         sreg_q       <= '0;
         cnt_q        <= '0;
         byte_valid_o <= 1'b0;
         byte_o       <= '0;
         done_o       <= 1'b0;
         bits_o       <= '0;
         ok_o         <= 1'b0;
      end else begin
         byte_valid_o <= bv_nx;
         byte_o       <= bd_nx;
         done_o       <= flush_i;
         if (flush_i) begin
            bits_o <= c_nx;
            ok_o   <= (int'(c_nx) >= MIN_BITS);
            sreg_q <= '0;
            cnt_q  <= '0;
         end else begin
            sreg_q <= s_nx;
            cnt_q  <= c_nx;
         end
      end
   end

   assign cnt_o = cnt_q;

   // R10: after a frame report the bit store starts empty
   p_clear_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> cnt_q == '0);
   // R9: a mid-frame byte leaves at most one bit of the next byte behind
   p_byte_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_o && !done_o) |-> (cnt_q[POS_W-1:0] <= POS_W'(1)));
endmodule

// File: rtl/uplink_pause_decoder.sv
module uplink_pause_decoder
   import upd_pkg::*;
#(
   parameter int TICK_DIV    = 1,
   parameter int PAUSE_TICKS = 24,
   parameter int LIM_ONE     = 48,
   parameter int LIM_TWO     = 80,
   parameter int LIM_THREE   = 112,
   parameter int EOF_TICKS   = 160,
   parameter int MIN_BITS    = 4,
   parameter int BCNT_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rearm,
   input  logic              mod_in,
   output logic              byte_valid,
   output logic [7:0]        byte_data,
   output logic              frame_done,
   output logic [BCNT_W-1:0] frame_bits,
   output logic              frame_ok
);
   initial begin
      assert (LIM_ONE < LIM_TWO && LIM_TWO < LIM_THREE && LIM_THREE < EOF_TICKS)
         else $error("interval limits must rise strictly");
      assert (PAUSE_TICKS < LIM_ONE) else $error("pause wait must be below LIM_ONE");
      assert (BYTE_W == 8) else $error("byte port is 8 bits wide");
   end

   dec_state_t        st_q;
   logic              mod_q, edge_w, act, tick;
   logic              pause_w, ev_w, eof_w;
   gap_cls_t          cls_w;
   logic              odd_q, first_q, odd_nx, first_nx;
   logic [1:0]        nb;
   logic              b0, b1, flush;
   logic [BCNT_W-1:0] pk_cnt;

   assign edge_w = mod_in ^ mod_q;
   assign act    = (st_q == ST_LIVE);

   always_ff @(posedge clk) begin
      if (!rst_n) mod_q <= 1'b0;
      else        mod_q <= mod_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || rearm) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (mod_in && !mod_q) st_q <= ST_LIVE;
            ST_LIVE: if (eof_w) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   upd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick));

   upd_pause_det #(.PAUSE_TICKS(PAUSE_TICKS)) u_pause (
      .clk(clk), .rst_n(rst_n), .act_i(act), .tick_i(tick),
      .edge_i(edge_w), .pause_o(pause_w));

   upd_gap_timer #(
      .LIM_ONE(LIM_ONE), .LIM_TWO(LIM_TWO),
      .LIM_THREE(LIM_THREE), .EOF_TICKS(EOF_TICKS)
   ) u_gap (
      .clk(clk), .rst_n(rst_n), .act_i(act), .tick_i(tick),
      .pause_i(pause_w), .ev_o(ev_w), .cls_o(cls_w), .eof_o(eof_w));

   // Half-bit phase rules: decide which bits each classified interval yields
   always_comb begin
      nb       = 2'd0;
      b0       = 1'b0;
      b1       = 1'b0;
      flush    = 1'b0;
      odd_nx   = odd_q;
      first_nx = first_q;
      if (act) begin
         if (eof_w) begin
            flush = 1'b1;
            if (odd_q) begin
               nb = 2'd1;
               b0 = 1'b1;
            end
         end else if (ev_w && cls_w != CLS_NONE) begin
            first_nx = 1'b0;
            unique case (cls_w)
               CLS_TWO: begin
                  if (!odd_q) begin
                     nb = 2'd1;
                     b0 = 1'b0;
                  end else if (!first_q) begin
                     nb = 2'd1;
                     b0 = 1'b1;
                  end
               end
               CLS_THREE, CLS_FOUR: begin
                  if (cls_w == CLS_THREE) odd_nx = !odd_q;
                  if (odd_q) begin
                     if (first_q) begin
                        nb = 2'd1;
                        b0 = 1'b0;
                     end else begin
                        nb = 2'd2;
                        b0 = 1'b1;
                        b1 = 1'b0;
                     end
                  end else if (cls_w == CLS_THREE) begin
                     nb = 2'd1;
                     b0 = 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || rearm || st_q == ST_IDLE) begin
         odd_q   <= 1'b1;
         first_q <= 1'b1;
      end else begin
         odd_q   <= odd_nx;
         first_q <= first_nx;
      end
   end

   upd_bit_packer #(.BCNT_W(BCNT_W), .MIN_BITS(MIN_BITS)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr_i(rearm),
      .nb_i(nb), .b0_i(b0), .b1_i(b1), .flush_i(flush),
      .cnt_o(pk_cnt), .byte_valid_o(byte_valid), .byte_o(byte_data),
      .done_o(frame_done), .bits_o(frame_bits), .ok_o(frame_ok));

   // R3: a short interval adds no bits
   p_short_gap_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act && ev_w && cls_w == CLS_NONE && !eof_w && !rearm) |=> $stable(pk_cnt));
   // R6: four half-bits in even phase add no bits
   p_four_even_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act && ev_w && cls_w == CLS_FOUR && !odd_q && !eof_w && !rearm) |=> $stable(pk_cnt));
   // R7: the first two-half-bit interval in odd phase adds no bits
   p_first_two_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && ev_w && cls_w == CLS_TWO && odd_q && first_q && !eof_w && !rearm)
      |=> $stable(pk_cnt));
   // R8: a frame report comes only after the decoder has gone idle
   p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> st_q == ST_IDLE);
   // R12: re-arm silences both strobes
   p_rearm_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |=> (!byte_valid && !frame_done));
endmodule

// File: tb/sim_uplink_pause_decoder.sv
`timescale 1ns/1ps
module sim_uplink_pause_decoder;
   localparam int BW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rearm = 1'b0;
   logic          mod_in = 1'b0;
   logic          byte_valid, frame_done, frame_ok;
   logic [7:0]    byte_data;
   logic [BW-1:0] frame_bits;

   always #10 clk = ~clk;

   uplink_pause_decoder #(.TICK_DIV(1), .BCNT_W(BW)) u0 (
      .clk(clk), .rst_n(rst_n), .rearm(rearm), .mod_in(mod_in),
      .byte_valid(byte_valid), .byte_data(byte_data),
      .frame_done(frame_done), .frame_bits(frame_bits), .frame_ok(frame_ok));

   int   n_chk = 0;
   int   n_bad = 0;
   bit   reported = 1'b0;

   logic [7:0] q_byte[$];
   string      q_btag[$];
   int         q_bits[$];
   bit         q_ok[$];

   task automatic check(bit cond, string req, string what, int act, int exp);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   // Monitor: pop the expected item for every strobe the design raises
   always @(negedge clk) begin : mon
      logic [7:0] eb;
      string      et;
      int         en;
      bit         eo;
      if (rst_n) begin
         if (byte_valid) begin
            if (q_byte.size() == 0) check(1'b0, "R12", "unexpected byte", byte_data, 0);
            else begin
               eb = q_byte.pop_front();
               et = q_btag.pop_front();
               check(byte_data == eb, et, "byte", byte_data, eb);
            end
         end
         if (frame_done) begin
            if (q_bits.size() == 0) check(1'b0, "R12", "unexpected frame", frame_bits, 0);
            else begin
               en = q_bits.pop_front();
               eo = q_ok.pop_front();
               check(int'(frame_bits) == en, "R11", "frame bit count", frame_bits, en);
               check(frame_ok == eo, "R11", "frame_ok", frame_ok, eo);
            end
         end
      end
   end

   // One half-bit: modulated halves toggle the flag every 4 clocks
   task automatic half(bit m);
      for (int k = 0; k < 32; k++) begin
         @(negedge clk);
         mod_in = m && ((k / 4) % 2 == 0);
      end
   endtask

   task automatic silence(int n);
      repeat (n) begin
         @(negedge clk);
         mod_in = 1'b0;
      end
   endtask

   task automatic expect_frame(int n, bit ok);
      q_bits.push_back(n);
      q_ok.push_back(ok);
   endtask

   // Driver: Manchester-encode n data bits after a start-of-frame half pair
   task automatic send_bits(int n, logic [63:0] d);
      int rem;
      logic [7:0] pb;
      for (int i = 0; i < n / 8; i++) begin
         q_byte.push_back(d[8*i +: 8]);
         q_btag.push_back("R9");
      end
      rem = n % 8;
      if (rem != 0) begin
         pb = d[8*(n/8) +: 8] & 8'((1 << rem) - 1);
         q_byte.push_back(pb);
         q_btag.push_back("R10");
      end
      expect_frame(n, n >= 4);
      half(1'b1);
      half(1'b0);
      for (int i = 0; i < n; i++) begin
         if (d[i]) begin half(1'b1); half(1'b0); end
         else begin half(1'b0); half(1'b1); end
      end
      silence(300);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      check(1'b0, "R11", "watchdog expired", 0, 1);
      report();
   end

   initial begin : stim
      repeat (4) @(negedge clk);
      check(byte_valid == 1'b0, "R1", "byte_valid in reset", byte_valid, 0);
      check(frame_done == 1'b0, "R1", "frame_done in reset", frame_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(byte_valid == 1'b0, "R1", "byte_valid after reset", byte_valid, 0);
      check(frame_done == 1'b0, "R1", "frame_done after reset", frame_done, 0);
      silence(20);

      // R8: odd phase at end appends the lone 1; R7 drops the start-of-frame one
      send_bits(1, 64'h1);
      // R5, R7: first three-half interval yields the single 0
      send_bits(1, 64'h0);
      // R11: 3 bits is below the minimum
      send_bits(3, 64'b101);
      // R11: exactly the minimum; R6 odd four-half path via 0,1 transitions
      send_bits(4, 64'b0110);
      // R9, R2: full byte, mixed intervals
      send_bits(8, 64'hA5);
      // R10: one byte plus a single right-aligned bit
      send_bits(9, 64'h13C);
      // R4: all ones means only two-half intervals in odd phase
      send_bits(16, 64'hFFFF);
      // R4, R5: all zeros uses three-half then even two-half intervals
      send_bits(16, 64'h0000);
      // R9, R10: long frame with a 3-bit tail
      send_bits(27, 64'h4D29B37);

      // R6: raw halves 10 01 0011 -> one 0 bit; even four-half interval adds nothing
      q_byte.push_back(8'h00);
      q_btag.push_back("R6");
      expect_frame(1, 1'b0);
      half(1'b1); half(1'b0); half(1'b0); half(1'b1);
      half(1'b0); half(1'b0); half(1'b1); half(1'b1);
      silence(300);

      // R3: a short glitch after the start modulation yields an ignored interval
      q_byte.push_back(8'h01);
      q_btag.push_back("R3");
      expect_frame(1, 1'b0);
      half(1'b1);
      silence(26);
      repeat (4) begin @(negedge clk); mod_in = 1'b1; end
      silence(300);

      // R12: re-arm mid-frame drops everything until released
      half(1'b1); half(1'b0); half(1'b1); half(1'b0);
      @(negedge clk);
      rearm = 1'b1;
      mod_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(byte_valid == 1'b0, "R12", "byte_valid under rearm", byte_valid, 0);
      check(frame_done == 1'b0, "R12", "frame_done under rearm", frame_done, 0);
      half(1'b0); half(1'b1); half(1'b1); half(1'b0);
      silence(300);
      rearm = 1'b0;
      silence(10);
      send_bits(8, 64'h3E);

      silence(20);
      check(q_byte.size() == 0, "R9", "bytes still expected", q_byte.size(), 0);
      check(q_bits.size() == 0, "R11", "frames still expected", q_bits.size(), 0);
      report();
   end
endmodule